// File: doc/BRIEF.md
# Rate-Paced Circular Clock-Crossing Queue

This block carries data words from a slower, free-running write clock into a faster read clock. It has no full or empty flags and no exchange of pointers between the domains. The write side stores one word on every write-clock cycle into an eight-slot ring. The read side runs on the fast clock, but its pointer only moves on cycles picked by a pacing pattern. In the main mode that pattern gives, on average, the same rate as the write clock, so the read pointer trails the write pointer at a steady distance.

The pacing pattern comes from a fractional accumulator. A select input picks one of four modes: the nominal ratio, every cycle, every other cycle, or stopped. Two slip pulses let an outside tracking loop nudge the distance between the pointers by one slot at a time. A late slip drops one advance and an early slip inserts one. Each advance loads a registered read word and raises a one-cycle valid strobe.

Top module: `throttled_cdc_fifo`

## Requirements
- R1: On every write-clock cycle out of reset, the write side stores `wr_data` into the slot at its pointer and then increments the pointer, wrapping from the last slot to slot 0. There is no stall or enable.
- R2: Reset state:
  - During read reset, `rd_valid` is 0 and `rd_data` is 0.
  - The read pointer starts `INIT_GAP` slots behind the write pointer, at slot `DEPTH - INIT_GAP`.
  - Write reset clears every slot to 0, so a slot not yet written reads as 0.
- R3: With `pace_sel` = 0 (ratio mode), any `RATE_DEN` consecutive read cycles hold exactly `RATE_NUM` advances. The accumulator starts from zero, so after reset release the first advance falls on the second read cycle.
- R4: With `pace_sel` = 1 (full rate), the read side advances on every read cycle.
- R5: With `pace_sel` = 2 (half rate), the read side advances on exactly one cycle of every two.
- R6: With `pace_sel` = 3 (hold), there are no advances, `rd_valid` stays 0 and `rd_data` keeps its value.
- R7: On the read cycle in which `pace_sel` differs from the mode in use, there is no advance and the accumulator restarts from zero. Going from full rate to ratio mode therefore gives 0, 0, 1 advances over the first three cycles.
- R8: A one-cycle `slip_late` pulse removes the next advance the pattern would have made. This gives exactly one advance fewer, and the accumulator is left untouched.
- R9: A one-cycle `slip_early` pulse inserts one advance on the next cycle in which the pattern makes none and the mode is not changing. This gives exactly one advance more.
- R10: On each advance, `rd_data` loads the slot at the read pointer, `rd_valid` is high for that one cycle, and the pointer increments modulo the depth. Without an advance, `rd_valid` is 0 and `rd_data` is unchanged.
- R11: When `slip_early` and `slip_late` arrive in the same cycle, or one arrives while the other is pending, they cancel and the advance count is unchanged. At most one slip is held pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Slow write clock, free-running |
| wrst_n | input | 1 | Active-low asynchronous reset of the write side |
| wr_data | input | DATA_W | Word stored on every write-clock cycle |
| rclk | input | 1 | Fast read clock |
| rrst_n | input | 1 | Active-low asynchronous reset of the read side |
| pace_sel | input | 2 | Advance pattern: 0 ratio, 1 full, 2 half, 3 hold |
| slip_late | input | 1 | One-cycle pulse: drop the next advance |
| slip_early | input | 1 | One-cycle pulse: add one advance |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | High for one read cycle on each advance |

## Verification
The bench builds the block with its defaults: 16-bit words, eight slots, a 2:3 pacing ratio and a starting gap of four. It runs the read clock at 100 MHz and the write clock at two thirds of that, with the edges of the two clocks never coinciding. This lets a slot-by-slot shadow of the ring predict every read word, including the four reset-zero reads at start-up and the reads after slips and non-ratio modes have moved the gap far from four. A window of thirty cycles is a multiple of both the ratio period and the half-rate period, so the advance count in each window is exact, and any lost or extra slip shows up as a count off by one.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
package tcf_pkg;

  typedef enum logic [1:0] {
    PACE_RATIO = 2'd0,
    PACE_FULL  = 2'd1,
    PACE_HALF  = 2'd2,
    PACE_HOLD  = 2'd3
  } pace_e;

  typedef enum logic [1:0] {
    SLIP_NONE  = 2'd0,
    SLIP_EARLY = 2'd1,
    SLIP_LATE  = 2'd2
  } slip_e;

  // increment added to the accumulator each read cycle
  function automatic int unsigned pace_num(pace_e mode, int unsigned ratio_num);
    case (mode)
      PACE_RATIO: return ratio_num;
      PACE_FULL:  return 1;
      PACE_HALF:  return 1;
      default:    return 0;
    endcase
  endfunction

  // threshold at which an advance is emitted
  function automatic int unsigned pace_den(pace_e mode, int unsigned ratio_den);
    case (mode)
      PACE_RATIO: return ratio_den;
      PACE_FULL:  return 1;
      PACE_HALF:  return 2;
      default:    return 1;
    endcase
  endfunction

  // fold new slip pulses into the (already consumed) pending state
  function automatic slip_e slip_merge(slip_e cur, logic early, logic late);
    if (early && !late)
      return (cur == SLIP_LATE) ? SLIP_NONE : SLIP_EARLY;
    else if (late && !early)
      return (cur == SLIP_EARLY) ? SLIP_NONE : SLIP_LATE;
    else
      return cur;
  endfunction

endpackage

// File: rtl/tcf_wr_ring.sv
`timescale 1ns/1ps
module tcf_wr_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                         wclk,
  input  logic                         wrst_n,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0] store_q,
  output logic [AW-1:0]                wr_ptr
);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      store_q <= '0;
      wr_ptr  <= '0;
    end else begin
      store_q[wr_ptr] <= wr_data;
      wr_ptr          <= wr_ptr + 1'b1;
    end
  end

  assert_wr_step_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
    wrst_n |=> (wr_ptr == $past(wr_ptr) + 1'b1));

endmodule

// File: rtl/tcf_pace_gen.sv
`timescale 1ns/1ps
module tcf_pace_gen
  import tcf_pkg::*;
#(
  parameter int RATE_NUM = 2,
  parameter int RATE_DEN = 3,
  parameter int ACC_W    = 3
) (
  input  logic  rclk,
  input  logic  rrst_n,
  input  pace_e mode,
  output logic  base_adv,
  output logic  mode_chg
);

  logic [ACC_W-1:0] acc_q, acc_d;
  pace_e            mode_q;
  int unsigned      num_c, den_c, sum_c;

  always_comb begin
    num_c    = pace_num(mode, RATE_NUM);
    den_c    = pace_den(mode, RATE_DEN);
    sum_c    = 32'(acc_q) + num_c;
    mode_chg = (mode != mode_q);
    base_adv = !mode_chg && (num_c != 0) && (sum_c >= den_c);
    if (mode_chg)
      acc_d = '0;
    else if (base_adv)
      acc_d = ACC_W'(sum_c - den_c);
    else if (num_c == 0)
      acc_d = acc_q;
    else
      acc_d = ACC_W'(sum_c);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      acc_q  <= '0;
      mode_q <= PACE_RATIO;
    end else begin
      acc_q  <= acc_d;
      mode_q <= mode;
    end
  end

  // remainder stays below the threshold outside a mode change
  assert_acc_bound_R3: assert property (@(posedge rclk) disable iff (!rrst_n)
    !mode_chg |-> (32'(acc_q) < den_c));

  // a change restarts the accumulator for the following cycle
  assert_restart_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    mode_chg |=> (acc_q == '0));

endmodule

// File: rtl/tcf_slip_ctl.sv
`timescale 1ns/1ps
module tcf_slip_ctl
  import tcf_pkg::*;
(
  input  logic  rclk,
  input  logic  rrst_n,
  input  pace_e mode,
  input  logic  base_adv,
  input  logic  mode_chg,
  input  logic  slip_late,
  input  logic  slip_early,
  output logic  adv
);

  slip_e pend_q, pend_d;
  logic  act_late, act_early;

  always_comb begin
    act_late  = (pend_q == SLIP_LATE) && base_adv;
    act_early = (pend_q == SLIP_EARLY) && !base_adv && !mode_chg;
    adv       = (base_adv && !act_late) || act_early;
    pend_d    = slip_merge((act_late || act_early) ? SLIP_NONE : pend_q,
                           slip_early, slip_late);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) pend_q <= SLIP_NONE;
    else         pend_q <= pend_d;
  end

  assert_full_rate_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode == PACE_FULL && !mode_chg && pend_q != SLIP_LATE) |-> adv);

  assert_hold_idle_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode == PACE_HOLD && !mode_chg && pend_q != SLIP_EARLY) |-> !adv);

  assert_chg_idle_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    mode_chg |-> !adv);

  assert_late_arm_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
    (slip_late && !slip_early && pend_q == SLIP_NONE) |=> (pend_q == SLIP_LATE));

  assert_early_arm_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
    (slip_early && !slip_late && pend_q == SLIP_NONE) |=> (pend_q == SLIP_EARLY));

  assert_cancel_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
    (slip_early && slip_late && pend_q == SLIP_NONE) |=> (pend_q == SLIP_NONE));

endmodule

// File: rtl/tcf_rd_port.sv
`timescale 1ns/1ps
module tcf_rd_port #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int INIT_GAP = 4,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                         rclk,
  input  logic                         rrst_n,
  input  logic                         adv,
  input  logic [DEPTH-1:0][DATA_W-1:0] store_q,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_valid
);

  localparam logic [AW-1:0] START = AW'(DEPTH - INIT_GAP);

  logic [AW-1:0] rd_ptr;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rd_ptr   <= START;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= adv;
      if (adv) begin
        rd_data <= store_q[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end

  assert_reset_state_R2: assert property (@(posedge rclk)
    !rrst_n |=> (!rd_valid && rd_data == '0 && rd_ptr == START));

  assert_adv_step_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
    adv |=> (rd_valid && rd_ptr == $past(rd_ptr) + 1'b1));

  assert_idle_hold_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
    !adv |=> (!rd_valid && $stable(rd_data) && $stable(rd_ptr)));

endmodule

// File: rtl/throttled_cdc_fifo.sv
`timescale 1ns/1ps
module throttled_cdc_fifo
  import tcf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int RATE_NUM = 2,
  parameter int RATE_DEN = 3,
  parameter int INIT_GAP = DEPTH / 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic [1:0]        pace_sel,
  input  logic              slip_late,
  input  logic              slip_early,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int AW    = $clog2(DEPTH);
  localparam int ACC_W = $clog2(2 * RATE_DEN + 1);

  logic [DEPTH-1:0][DATA_W-1:0] store_q;
  logic [AW-1:0]                wr_ptr;
  pace_e                        mode_w;
  logic                         base_adv;
  logic                         mode_chg;
  logic                         adv_w;

  assign mode_w = pace_e'(pace_sel);

  tcf_wr_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wr (
    .wclk    (wclk),
    .wrst_n  (wrst_n),
    .wr_data (wr_data),
    .store_q (store_q),
    .wr_ptr  (wr_ptr)
  );

  tcf_pace_gen #(.RATE_NUM(RATE_NUM), .RATE_DEN(RATE_DEN), .ACC_W(ACC_W)) u_pace (
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .mode     (mode_w),
    .base_adv (base_adv),
    .mode_chg (mode_chg)
  );

  tcf_slip_ctl u_slip (
    .rclk       (rclk),
    .rrst_n     (rrst_n),
    .mode       (mode_w),
    .base_adv   (base_adv),
    .mode_chg   (mode_chg),
    .slip_late  (slip_late),
    .slip_early (slip_early),
    .adv        (adv_w)
  );

  tcf_rd_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INIT_GAP(INIT_GAP)) u_rd (
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .adv      (adv_w),
    .store_q  (store_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial begin
    assert_params_R3: assert (RATE_NUM <= RATE_DEN && INIT_GAP < DEPTH && (1 << AW) == DEPTH);
  end

endmodule

// File: tb/throttled_cdc_fifo_tb_top.sv
`timescale 1ns/1ps
module throttled_cdc_fifo_tb_top;

  localparam int DW   = 16;
  localparam int DEP  = 8;
  localparam int RN   = 2;
  localparam int RD   = 3;
  localparam int GAP  = 4;
  localparam int WIN  = 30;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          wrst_n = 1'b0;
  logic          rrst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    pace_sel = 2'd0;
  logic          slip_late = 1'b0;
  logic          slip_early = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  always #5   rclk = ~rclk;
  always #7.5 wclk = ~wclk;

  throttled_cdc_fifo #(.DATA_W(DW), .DEPTH(DEP), .RATE_NUM(RN), .RATE_DEN(RD),
                       .INIT_GAP(GAP)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_data(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .pace_sel(pace_sel),
    .slip_late(slip_late), .slip_early(slip_early),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_vec = 0;
  int n_bad = 0;
  int vcount = 0;
  int wslot = 0;
  int exp_ptr = DEP - GAP;
  bit finished = 1'b0;
  logic [DW-1:0] shadow [DEP] = '{default: '0};
  logic [DW-1:0] snap = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // R1: shadow ring mirrors one store per write-clock cycle
  always @(posedge wclk) begin
    if (wrst_n) begin
      shadow[wslot] <= wr_data;
      wslot <= (wslot + 1) % DEP;
    end
  end

  always @(posedge rclk) snap <= shadow[exp_ptr];

  // R10 (and R1, R2 through reset-zero slots): every read word checked
  always @(negedge rclk) begin
    if (rrst_n && rd_valid) begin
      check(rd_data == snap, "R10", "read word", rd_data, snap);
      exp_ptr = (exp_ptr + 1) % DEP;
      vcount++;
    end
  end

  initial begin
    forever begin
      @(negedge wclk);
      wr_data = DW'($urandom);
    end
  end

  function automatic int exp_count(input int mode, input int w);
    case (mode)
      0: return (w * RN) / RD;
      1: return w;
      2: return w / 2;
      default: return 0;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge rclk);
    #2;
  endtask

  task automatic window(input int mode, input bit early, input bit late, input string req);
    int st;
    pace_sel = 2'(mode);
    step(5);
    st = vcount;
    slip_early = early;
    slip_late = late;
    step(1);
    slip_early = 1'b0;
    slip_late = 1'b0;
    step(WIN - 1);
    check((vcount - st) == exp_count(mode, WIN) + int'(early) - int'(late), req,
          "advances in window", vcount - st, exp_count(mode, WIN) + int'(early) - int'(late));
  endtask

  initial begin
    int st;
    logic [DW-1:0] held;
    void'($urandom(32'h5eed_0042));
    #31;
    check(rd_valid == 1'b0, "R2", "rd_valid in reset", rd_valid, 0);
    check(rd_data == '0, "R2", "rd_data in reset", rd_data, 0);
    #70;
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    step(1);
    check(rd_valid == 1'b0, "R3", "no advance on first cycle", rd_valid, 0);
    step(1);
    check(rd_valid == 1'b1, "R3", "advance on second cycle", rd_valid, 1);

    window(0, 1'b0, 1'b0, "R3");
    window(1, 1'b0, 1'b0, "R4");
    window(2, 1'b0, 1'b0, "R5");

    // R6: hold mode keeps data and strobe still
    pace_sel = 2'd3;
    step(5);
    held = rd_data;
    st = vcount;
    step(WIN);
    check(vcount == st, "R6", "advances in hold", vcount - st, 0);
    check(rd_data == held, "R6", "rd_data held", rd_data, held);

    // R7: full rate then ratio gives 0,0,1 over the first three cycles
    pace_sel = 2'd1;
    step(5);
    pace_sel = 2'd0;
    step(1);
    st = vcount;
    step(3);
    check(vcount - st == 1, "R7", "advances after mode change", vcount - st, 1);

    window(0, 1'b0, 1'b1, "R8");
    window(0, 1'b1, 1'b0, "R9");
    window(0, 1'b1, 1'b1, "R11");
    window(2, 1'b1, 1'b0, "R9");
    window(2, 1'b0, 1'b1, "R8");
    window(2, 1'b1, 1'b1, "R11");

    for (int i = 0; i < 40; i++) begin
      int m;
      bit e, l;
      m = $urandom_range(0, 3);
      e = 1'b0;
      l = 1'b0;
      if (m == 0 || m == 2) begin
        e = 1'($urandom_range(0, 1));
        l = 1'($urandom_range(0, 1));
      end
      window(m, e, l, (e || l) ? "R8 R9 R11" : "R3 R4 R5 R6");
    end

    finished = 1'b1;
    summary();
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

endmodule